// File: doc/BRIEF.md
# Fused Vector-Update and Dot-Product Stream Engine

The engine computes, in a single streaming pass, the vector update `z = w - alpha*v` and the scalar `beta = sum(z*u)` over vectors of length N. Both operations run side by side. Each z beat leaves the update stage on the z output stream, and an on-chip copy of the same beat goes through a small FIFO into the dot-product stage. No second read of z is ever needed. Inputs and outputs are valid/ready streams that carry W signed fixed-point lanes per beat.

A job starts with a one-cycle `start` pulse. The pulse carries the element count and the scaling factor `alpha`. `alpha` uses FRAC fractional bits. Each z lane is saturated to the lane width. `beta` is accumulated at full precision and is delivered as one item on its own stream. `done` pulses once both the final z beat and `beta` have been taken by their consumers. After that pulse the engine accepts a new job.

Top module: `axpy_dot_chain`

## Requirements
- R1: Lane i of each z beat (bits [i*DW +: DW]) equals w_i - ((alpha*v_i) >>> FRAC), computed in two's complement with an arithmetic (floor) shift. The same lane slot is used on all streams.
- R2: A z lane whose exact result lies outside [-2^(DW-1), 2^(DW-1)-1] is clamped to the nearer limit.
- R3: Exactly one beta is produced per job, after the last z beat has been consumed by the dot stage. It equals the full-precision signed sum of z_i*u_i over all N elements.
- R4: A job produces exactly N/W z beats, in input order. z_data holds steady while z_valid is high and z_ready is low.
- R5: When z_ready is low the engine stops taking w and v. No z beat is lost or duplicated, and z remains correct under any z_ready pattern.
- R6: While u_valid is held low and z_ready is high, the update stage continues until the FIFO and the fork slot are full. That is exactly DEPTH+1 z beats. When u resumes, the job completes correctly.
- R7: A `start` is ignored if it arrives while a job is running, or if its length is zero, not a multiple of W, or above NMAX. An ignored start leaves w_ready low.
- R8: beta_data holds steady while beta_valid is high and beta_ready is low. `done` is a single-cycle pulse, raised only after both the last z beat and beta have been accepted.
- R9: During and after reset, z_valid, beta_valid, done, w_ready, v_ready and u_ready are all low.
- R10: When no stream stalls, `done` rises no later than N/W + 6 cycles after the clock edge that accepts `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Job request pulse |
| start_len | input | $clog2(NMAX+1) | Element count N |
| start_alpha | input | DW | Signed scale factor, FRAC fraction bits |
| w_valid | input | 1 | w beat valid |
| w_ready | output | 1 | w beat taken |
| w_data | input | W*DW | w lanes |
| v_valid | input | 1 | v beat valid |
| v_ready | output | 1 | v beat taken |
| v_data | input | W*DW | v lanes |
| u_valid | input | 1 | u beat valid |
| u_ready | output | 1 | u beat taken |
| u_data | input | W*DW | u lanes |
| z_valid | output | 1 | z beat valid |
| z_ready | input | 1 | z consumer ready |
| z_data | output | W*DW | z lanes |
| beta_valid | output | 1 | beta result valid |
| beta_ready | input | 1 | beta consumer ready |
| beta_data | output | 2*DW+$clog2(NMAX)+1 | Signed dot product |
| done | output | 1 | Job complete pulse |

## Verification
The bench builds the engine with W=4, DW=16, FRAC=8, NMAX=64 and DEPTH=4. With these values a 16-beat job is longer than the five-beat buffer made of the FIFO and the fork slot, so holding u off exposes the exact fill point. A large alpha against extreme w and v drives lanes into both saturation limits. Irregular z_ready and beta_ready patterns test the hold rules and the lossless back-pressure, while a stray start is injected in the middle of a job.

// File: rtl/axdot_pkg.sv
package axdot_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // Delivery flags of the single fork slot.
    typedef struct packed {
        logic to_out;   // still owed to the z output stream
        logic to_fifo;  // still owed to the coupling FIFO
        logic last;     // slot holds the final beat of the job
    } fork_flags_t;

    function automatic int acc_width(input int dw, input int nmax);
        return 2 * dw + $clog2(nmax) + 1;
    endfunction

endpackage

// File: rtl/axpy_lanes.sv
module axpy_lanes #(
    parameter int W    = 4,
    parameter int DW   = 16,
    parameter int FRAC = 8
) (
    input  logic [DW-1:0]   alpha,
    input  logic [W*DW-1:0] w_beat,
    input  logic [W*DW-1:0] v_beat,
    output logic [W*DW-1:0] z_beat
);
    localparam int XW = 2 * DW + 1;
    localparam logic signed [XW-1:0] SAT_HI = XW'((1 << (DW - 1)) - 1);
    localparam logic signed [XW-1:0] SAT_LO = -SAT_HI - XW'(1);

    for (genvar g = 0; g < W; g++) begin : g_lane
        logic signed [DW-1:0]   wl, vl, al;
        logic signed [2*DW-1:0] prod, scaled;
        logic signed [XW-1:0]   diff;

        assign wl = w_beat[g*DW +: DW];
        assign vl = v_beat[g*DW +: DW];
        assign al = alpha;

        always_comb begin
            prod   = al * vl;
            scaled = prod >>> FRAC;
            diff   = {{(DW + 1){wl[DW-1]}}, wl} - {scaled[2*DW-1], scaled};
            if (diff > SAT_HI)
                z_beat[g*DW +: DW] = SAT_HI[DW-1:0];
            else if (diff < SAT_LO)
                z_beat[g*DW +: DW] = SAT_LO[DW-1:0];
            else
                z_beat[g*DW +: DW] = diff[DW-1:0];
        end
    end

endmodule

// File: rtl/axpy_stage.sv
module axpy_stage
    import axdot_pkg::*;
#(
    parameter int W    = 4,
    parameter int DW   = 16,
    parameter int FRAC = 8,
    parameter int LENW = 11
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            load,
    input  logic [LENW-1:0] load_beats,
    input  logic [DW-1:0]   alpha,
    input  logic            w_valid,
    output logic            w_ready,
    input  logic [W*DW-1:0] w_data,
    input  logic            v_valid,
    output logic            v_ready,
    input  logic [W*DW-1:0] v_data,
    output logic            z_valid,
    input  logic            z_ready,
    output logic [W*DW-1:0] z_data,
    output logic            ff_push,
    input  logic            ff_full,
    output logic [W*DW-1:0] ff_data,
    output logic            last_out
);
    logic [LENW-1:0] left_q;
    logic [W*DW-1:0] slot_q, z_calc;
    fork_flags_t     fl_q;
    logic            out_pend, fifo_pend, slot_free, can_take, take;

    axpy_lanes #(.W(W), .DW(DW), .FRAC(FRAC)) u_lanes (
        .alpha  (alpha),
        .w_beat (w_data),
        .v_beat (v_data),
        .z_beat (z_calc)
    );

    assign out_pend  = fl_q.to_out && !z_ready;
    assign fifo_pend = fl_q.to_fifo && ff_full;
    assign slot_free = !out_pend && !fifo_pend;
    assign can_take  = run && (left_q != '0) && slot_free;
    assign take      = can_take && w_valid && v_valid;

    assign w_ready  = can_take && v_valid;
    assign v_ready  = can_take && w_valid;
    assign z_valid  = fl_q.to_out;
    assign z_data   = slot_q;
    assign ff_push  = fl_q.to_fifo && !ff_full;
    assign ff_data  = slot_q;
    assign last_out = fl_q.to_out && z_ready && fl_q.last;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            slot_q <= '0;
            fl_q   <= '0;
        end else begin
            if (load)
                left_q <= load_beats;
            else if (take)
                left_q <= left_q - LENW'(1);
            if (take) begin
                slot_q      <= z_calc;
                fl_q.to_out  <= 1'b1;
                fl_q.to_fifo <= 1'b1;
                fl_q.last    <= (left_q == LENW'(1));
            end else begin
                fl_q.to_out  <= out_pend;
                fl_q.to_fifo <= fifo_pend;
            end
        end
    end

    // R4: a z beat waiting on the consumer stays put
    p_z_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (z_valid && !z_ready) |=> (z_valid && $stable(z_data)));

    // R5: inputs are not taken while the z consumer stalls
    p_stall_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        (z_valid && !z_ready) |-> !w_ready);

endmodule

// File: rtl/sync_fifo.sv
module sync_fifo #(
    parameter int DWID  = 64,
    parameter int DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic [DWID-1:0] din,
    input  logic            pop,
    output logic [DWID-1:0] head,
    output logic            full,
    output logic            empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DWID-1:0] mem [DEPTH];
    logic [PW-1:0]   wp_q, rp_q;
    logic [CW-1:0]   cnt_q;

    assign full  = (cnt_q == CW'(DEPTH));
    assign empty = (cnt_q == '0);
    assign head  = mem[rp_q];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push)
            mem[wp_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wp_q <= bump(wp_q);
            if (pop)  rp_q <= bump(rp_q);
            if (push && !pop)
                cnt_q <= cnt_q + CW'(1);
            else if (pop && !push)
                cnt_q <= cnt_q - CW'(1);
        end
    end

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/dot_stage.sv
module dot_stage #(
    parameter int W    = 4,
    parameter int DW   = 16,
    parameter int LENW = 11,
    parameter int ACCW = 43
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [LENW-1:0] load_beats,
    input  logic            ff_empty,
    input  logic [W*DW-1:0] ff_head,
    output logic            ff_pop,
    input  logic            u_valid,
    output logic            u_ready,
    input  logic [W*DW-1:0] u_data,
    output logic            beta_valid,
    input  logic            beta_ready,
    output logic [ACCW-1:0] beta_data
);
    logic [LENW-1:0]        left_q;
    logic signed [ACCW-1:0] acc_q, beat_sum;
    logic [ACCW-1:0]        res_q;
    logic                   bval_q;
    logic signed [2*DW-1:0] prd [W];

    for (genvar g = 0; g < W; g++) begin : g_mul
        logic signed [DW-1:0] zl, ul;
        assign zl = ff_head[g*DW +: DW];
        assign ul = u_data[g*DW +: DW];
        assign prd[g] = zl * ul;
    end

    always_comb begin
        beat_sum = '0;
        for (int i = 0; i < W; i++)
            beat_sum = beat_sum + ACCW'(prd[i]);
    end

    assign u_ready    = (left_q != '0) && !ff_empty && !bval_q;
    assign ff_pop     = u_ready && u_valid;
    assign beta_valid = bval_q;
    assign beta_data  = res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            acc_q  <= '0;
            res_q  <= '0;
            bval_q <= 1'b0;
        end else begin
            if (load) begin
                left_q <= load_beats;
                acc_q  <= '0;
            end else if (ff_pop) begin
                left_q <= left_q - LENW'(1);
                if (left_q == LENW'(1)) begin
                    res_q  <= acc_q + beat_sum;
                    bval_q <= 1'b1;
                    acc_q  <= '0;
                end else begin
                    acc_q <= acc_q + beat_sum;
                end
            end
            if (bval_q && beta_ready)
                bval_q <= 1'b0;
        end
    end

    // R8: a waiting result keeps its value
    p_beta_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (beta_valid && !beta_ready) |=> (beta_valid && $stable(beta_data)));

    // R3: no further u is consumed while a result waits
    p_one_result_r3: assert property (@(posedge clk) disable iff (rst)
        beta_valid |-> !u_ready);

endmodule

// File: rtl/axpy_dot_chain.sv
module axpy_dot_chain
    import axdot_pkg::*;
#(
    parameter int W     = 4,
    parameter int DW    = 16,
    parameter int FRAC  = 8,
    parameter int NMAX  = 1024,
    parameter int DEPTH = 4,
    localparam int LENW = $clog2(NMAX + 1),
    localparam int ACCW = acc_width(DW, NMAX)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [LENW-1:0] start_len,
    input  logic [DW-1:0]   start_alpha,
    input  logic            w_valid,
    output logic            w_ready,
    input  logic [W*DW-1:0] w_data,
    input  logic            v_valid,
    output logic            v_ready,
    input  logic [W*DW-1:0] v_data,
    input  logic            u_valid,
    output logic            u_ready,
    input  logic [W*DW-1:0] u_data,
    output logic            z_valid,
    input  logic            z_ready,
    output logic [W*DW-1:0] z_data,
    output logic            beta_valid,
    input  logic            beta_ready,
    output logic [ACCW-1:0] beta_data,
    output logic            done
);
    run_state_e      state_q;
    logic [DW-1:0]   alpha_q;
    logic [LENW-1:0] nbeats;
    logic            start_ok, z_fin_q, b_fin_q, done_q, last_out;
    logic            ff_push, ff_pop, ff_full, ff_empty;
    logic [W*DW-1:0] ff_din, ff_head;

    assign nbeats   = start_len / LENW'(W);
    assign start_ok = (state_q == ST_IDLE) && start && (start_len != '0)
                   && ((start_len % LENW'(W)) == '0)
                   && (start_len <= LENW'(NMAX));

    axpy_stage #(.W(W), .DW(DW), .FRAC(FRAC), .LENW(LENW)) u_upd (
        .clk        (clk),
        .rst        (rst),
        .run        (state_q == ST_RUN),
        .load       (start_ok),
        .load_beats (nbeats),
        .alpha      (alpha_q),
        .w_valid    (w_valid),
        .w_ready    (w_ready),
        .w_data     (w_data),
        .v_valid    (v_valid),
        .v_ready    (v_ready),
        .v_data     (v_data),
        .z_valid    (z_valid),
        .z_ready    (z_ready),
        .z_data     (z_data),
        .ff_push    (ff_push),
        .ff_full    (ff_full),
        .ff_data    (ff_din),
        .last_out   (last_out)
    );

    sync_fifo #(.DWID(W * DW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (ff_push),
        .din   (ff_din),
        .pop   (ff_pop),
        .head  (ff_head),
        .full  (ff_full),
        .empty (ff_empty)
    );

    dot_stage #(.W(W), .DW(DW), .LENW(LENW), .ACCW(ACCW)) u_dot (
        .clk        (clk),
        .rst        (rst),
        .load       (start_ok),
        .load_beats (nbeats),
        .ff_empty   (ff_empty),
        .ff_head    (ff_head),
        .ff_pop     (ff_pop),
        .u_valid    (u_valid),
        .u_ready    (u_ready),
        .u_data     (u_data),
        .beta_valid (beta_valid),
        .beta_ready (beta_ready),
        .beta_data  (beta_data)
    );

    assign done = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            alpha_q <= '0;
            z_fin_q <= 1'b0;
            b_fin_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_ok) begin
                state_q <= ST_RUN;
                alpha_q <= start_alpha;
            end
            if (last_out)
                z_fin_q <= 1'b1;
            if (beta_valid && beta_ready)
                b_fin_q <= 1'b1;
            if (state_q == ST_RUN && z_fin_q && b_fin_q) begin
                state_q <= ST_IDLE;
                z_fin_q <= 1'b0;
                b_fin_q <= 1'b0;
                done_q  <= 1'b1;
            end
        end
    end

    // R7: an idle engine takes no stream data
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> (!w_ready && !v_ready && !u_ready && !z_valid));

    // R8: done lasts one cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: done follows both completions
    p_done_after_both_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(z_fin_q && b_fin_q));

endmodule

// File: tb/axpy_dot_chain_tb_top.sv
module axpy_dot_chain_tb_top;
    localparam int W = 4, DW = 16, FRAC = 8, NMAX = 64, DEPTH = 4;
    localparam int LENW = $clog2(NMAX + 1);
    localparam int ACCW = 2 * DW + $clog2(NMAX) + 1;

    logic clk = 1'b0, rst = 1'b1;
    logic start = 1'b0;
    logic [LENW-1:0] start_len = '0;
    logic [DW-1:0] start_alpha = '0;
    logic w_valid = 1'b0, v_valid = 1'b0, u_valid = 1'b0;
    logic w_ready, v_ready, u_ready;
    logic [W*DW-1:0] w_data = '0, v_data = '0, u_data = '0;
    logic z_valid, z_ready, beta_valid, beta_ready, done;
    logic [W*DW-1:0] z_data;
    logic [ACCW-1:0] beta_data;

    always #5 clk = ~clk;

    axpy_dot_chain #(.W(W), .DW(DW), .FRAC(FRAC), .NMAX(NMAX), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .start(start), .start_len(start_len),
        .start_alpha(start_alpha),
        .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
        .v_valid(v_valid), .v_ready(v_ready), .v_data(v_data),
        .u_valid(u_valid), .u_ready(u_ready), .u_data(u_data),
        .z_valid(z_valid), .z_ready(z_ready), .z_data(z_data),
        .beta_valid(beta_valid), .beta_ready(beta_ready), .beta_data(beta_data),
        .done(done)
    );

    int nchk = 0, nfail = 0, cyc = 0;
    int zmode = 0, bmode = 0;
    int job_id = 0, job_nb = 0, zseen = 0, dones = 0;
    bit bseen = 0;
    logic [W*DW-1:0] zq[$];
    longint bq[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int gen_w(int kind, int j, int i);
        if (kind == 1) return (i % 2 == 1) ? 32767 : -32768;
        return ((i * 1237 + j * 311) % 4001) - 2000;
    endfunction
    function automatic int gen_v(int kind, int j, int i);
        if (kind == 1) return (i % 2 == 1) ? -30000 : 30000;
        return ((i * 733 + j * 97) % 3001) - 1500;
    endfunction
    function automatic int gen_u(int j, int i);
        return ((i * 59 + j * 13) % 401) - 200;
    endfunction
    function automatic longint model_z(int a, int wv, int vv);
        longint p, d;
        p = longint'(a) * longint'(vv);
        d = longint'(wv) - (p >>> FRAC);
        if (d > 32767) d = 32767;
        if (d < -32768) d = -32768;
        return d;
    endfunction

    // stall pattern drivers for the output consumers
    initial begin
        z_ready = 1'b0;
        beta_ready = 1'b0;
        forever begin
            @(posedge clk); #1;
            cyc++;
            z_ready    = (zmode == 0) || (((cyc * 7) % 5) < 3);
            beta_ready = (bmode == 0) || (cyc % 4 == 0);
        end
    end

    // scoreboard monitor
    initial begin
        logic [W*DW-1:0] zprev, zexp;
        logic [ACCW-1:0] bprev;
        bit zhold = 0, bhold = 0;
        longint bexp;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (zhold) chk(z_valid && z_data == zprev, "R4", "z held", longint'(z_data), longint'(zprev));
                if (bhold) chk(beta_valid && beta_data == bprev, "R8", "beta held", longint'(beta_data), longint'(bprev));
                if (z_valid && z_ready) begin
                    zexp = (zq.size() > 0) ? zq.pop_front() : 'x;
                    chk(z_data === zexp, "R1 R2 R5", "z beat", longint'(z_data), longint'(zexp));
                    zseen++;
                end
                if (beta_valid && beta_ready) begin
                    bexp = (bq.size() > 0) ? bq.pop_front() : 0;
                    chk(longint'($signed(beta_data)) == bexp, "R3", "beta", longint'($signed(beta_data)), bexp);
                    bseen = 1;
                end
                if (done) begin
                    chk(zseen == job_nb && bseen, "R8", "done after z and beta", zseen, job_nb);
                    dones++;
                end
                zhold = z_valid && !z_ready;  zprev = z_data;
                bhold = beta_valid && !beta_ready; bprev = beta_data;
            end
        end
    end

    task automatic run_job(input int nb, input int kind, input int alpha,
                           input int zm, input int bm, input bit uhold,
                           input bit poke, input bit timed);
        longint bsum = 0;
        int k = 0;
        job_id++;
        job_nb = nb; zseen = 0; bseen = 0; dones = 0;
        zmode = zm; bmode = bm;
        for (int b = 0; b < nb; b++) begin
            logic [W*DW-1:0] zb;
            for (int l = 0; l < W; l++) begin
                int e = b * W + l;
                longint z = model_z(alpha, gen_w(kind, job_id, e), gen_v(kind, job_id, e));
                zb[l*DW +: DW] = DW'(z);
                bsum += z * longint'(gen_u(job_id, e));
            end
            zq.push_back(zb);
        end
        bq.push_back(bsum);
        @(posedge clk); #1;
        start = 1; start_len = LENW'(nb * W); start_alpha = DW'(alpha);
        @(posedge clk); #1;
        start = 0;
        fork
            begin
                for (int b = 0; b < nb; b++) begin
                    for (int l = 0; l < W; l++) begin
                        w_data[l*DW +: DW] = DW'(gen_w(kind, job_id, b * W + l));
                        v_data[l*DW +: DW] = DW'(gen_v(kind, job_id, b * W + l));
                    end
                    w_valid = 1; v_valid = 1;
                    do @(negedge clk); while (!w_ready);
                    @(posedge clk); #1;
                end
                w_valid = 0; v_valid = 0;
            end
            begin
                if (uhold) begin
                    repeat (40) @(posedge clk);
                    #1;
                    chk(zseen == DEPTH + 1, "R6", "z beats with u held", zseen, DEPTH + 1);
                end
                for (int b = 0; b < nb; b++) begin
                    for (int l = 0; l < W; l++)
                        u_data[l*DW +: DW] = DW'(gen_u(job_id, b * W + l));
                    u_valid = 1;
                    do @(negedge clk); while (!u_ready);
                    @(posedge clk); #1;
                end
                u_valid = 0;
            end
            begin
                if (poke) begin
                    repeat (5) @(posedge clk);
                    #1; start = 1; start_len = LENW'(2 * W);
                    @(posedge clk); #1; start = 0;
                end
            end
            begin
                @(negedge clk);
                while (!done) begin k++; @(negedge clk); end
            end
        join
        if (timed) chk(k <= nb + 6, "R10", "cycles to done", k, nb + 6);
        repeat (4) @(negedge clk);
        chk(zseen == nb && zq.size() == 0, "R4", "z beat count", zseen, nb);
        chk(dones == 1 && bq.size() == 0, "R3", "one beta and one done", dones, 1);
        chk(w_ready == 0, "R7", "idle after job", w_ready, 0);
    endtask

    task automatic bad_start(input int len);
        bit seen = 0;
        @(posedge clk); #1;
        w_valid = 1; v_valid = 1;
        start = 1; start_len = LENW'(len);
        @(posedge clk); #1; start = 0;
        repeat (8) begin
            @(negedge clk);
            if (w_ready || v_ready) seen = 1;
        end
        chk(!seen, "R7", "ignored start", len, 0);
        @(posedge clk); #1;
        w_valid = 0; v_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!z_valid && !beta_valid && !done && !w_ready && !v_ready && !u_ready,
            "R9", "outputs in reset", 1, 0);
        @(posedge clk); #1; rst = 0;
        @(negedge clk);
        chk(!z_valid && !beta_valid && !done && !w_ready && !u_ready,
            "R9", "outputs after reset", 1, 0);
        run_job(4, 0, 384, 0, 0, 0, 0, 1);
        run_job(8, 1, 1000, 0, 0, 0, 0, 1);
        run_job(16, 0, -200, 1, 1, 0, 1, 0);
        run_job(16, 0, 128, 0, 0, 1, 0, 0);
        bad_start(6);
        bad_start(0);
        bad_start(NMAX + W);
        run_job(2, 0, -512, 1, 0, 0, 0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule